// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block sits in front of a synchronous burst memory. It keeps a word address and produces the address of each beat of a four-beat burst. A new start address is captured when either of two active-low start strobes is asserted. One strobe belongs to a cache controller and always loads. The other belongs to a processor and loads only while the chip enable is low.

After the load, an active-low advance input moves the burst forward by one beat per clock. While advance is high, the burst is suspended and the same address is presented again. Only the two lowest address bits change during a burst. A strap input picks the order of those two bits. When it is high, the order is interleaved: each beat's low bits are the start bits XORed with the beat count. When it is low, the order is linear: the low bits count upward modulo four from the start value. After the fourth beat, the burst returns to its first address.

Both outputs are taken straight from registers through the ordering logic, so the beat's address is valid in the cycle that follows the clock edge that caused it. A synchronous reset clears all state. A clock-enable input freezes all state.

Top module: `burst_addr_gen`

## Requirements
- R1: When `ctl_strobe_n` is low at an enabled rising edge, `start_addr` is captured and `beat` becomes 0, whatever the level of `chip_en_n`. After that edge, `cur_addr` equals `start_addr`.
- R2: When `cpu_strobe_n` is low at an enabled edge, the load of R1 happens only if `chip_en_n` is also low. If `chip_en_n` is high, the processor strobe is ignored, and `cur_addr` and `beat` behave as if the strobe were high.
- R3: At an enabled edge with no load and `adv_n` low, `beat` increments by one modulo 4.
- R4: At an enabled edge with no load and `adv_n` high, `beat` and `cur_addr` hold their values (burst suspended).
- R5: With `order_xor` = 1 (interleaved), `cur_addr[1:0]` equals the captured start bits [1:0] XOR `beat`.
- R6: With `order_xor` = 0 (linear), `cur_addr[1:0]` equals (captured start bits [1:0] + `beat`) mod 4. In both modes, a fourth advance returns `beat` to 0 and `cur_addr` to the start address.
- R7: `cur_addr[14:2]` equals the captured `start_addr[14:2]` and never changes without a load.
- R8: A load at an edge takes priority over a simultaneous advance: `beat` becomes 0, not the incremented value.
- R9: `rst` high at a rising edge clears `cur_addr` and `beat` to 0. This happens regardless of `clk_en`.
- R10: With `clk_en` low, an edge changes nothing, even with strobes or advance asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low freezes all state |
| ctl_strobe_n | input | 1 | Cache-controller start strobe, active low, not gated |
| cpu_strobe_n | input | 1 | Processor start strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low, qualifies the processor strobe |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Static strap: 1 = interleaved order, 0 = linear order |
| start_addr | input | 15 | Start word address captured on a load |
| cur_addr | output | 15 | Address of the current beat |
| beat | output | 2 | Position within the burst, 0 to 3 |

## Verification
Two events can fall in the same cycle: a start strobe and an advance. Two start strobes can also be asserted together while the chip enable is high. The bench provokes the first case by asserting a strobe with `adv_n` low partway through a burst. It judges the result by checking that `beat` is 0 and `cur_addr` is the new start, not the next beat of the old burst. For the second case, it asserts the processor strobe with chip enable high, both alone and with advance low. It checks that only the advance acts.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Four-beat burst: the lane is the low part of the address that moves.
  localparam int unsigned LANE_W = 2;

  typedef logic [LANE_W-1:0] lane_t;

  // Interleaved order: every lane bit flips when the matching beat bit is set.
  function automatic lane_t lane_interleave(input lane_t start_lo, input lane_t pos);
    return start_lo ^ pos;
  endfunction

  // Linear order: wrap-around addition inside the lane.
  function automatic lane_t lane_linear(input lane_t start_lo, input lane_t pos);
    return lane_t'(start_lo + pos);
  endfunction

  // Next beat position, wrapping after the last beat.
  function automatic lane_t lane_next(input lane_t pos);
    return lane_t'(pos + lane_t'(1));
  endfunction

  // Load decision: controller strobe is ungated, processor strobe needs chip enable.
  function automatic logic start_request(input logic ctl_n, input logic cpu_n,
                                         input logic ce_n);
    return (!ctl_n) || (!cpu_n && !ce_n);
  endfunction

endpackage

// File: rtl/bag_strobe_qual.sv
module bag_strobe_qual (
  input  logic clk_en,
  input  logic ctl_strobe_n,
  input  logic cpu_strobe_n,
  input  logic chip_en_n,
  output logic load_fire
);
  import bag_pkg::*;

  always_comb begin
    load_fire = clk_en && start_request(ctl_strobe_n, cpu_strobe_n, chip_en_n);
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clk_en,
  input  logic                      load_fire,
  input  logic                      adv_n,
  output logic                      step_fire,
  output logic [bag_pkg::LANE_W-1:0] beat
);
  import bag_pkg::*;

  lane_t beat_q;

  // Advance only when no load owns this edge.
  always_comb begin
    step_fire = clk_en && !load_fire && !adv_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (load_fire) begin
      beat_q <= '0;
    end else if (step_fire) begin
      beat_q <= lane_next(beat_q);
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_fire,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base_addr
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (load_fire) begin
      base_q <= start_addr;
    end
  end

  assign base_addr = base_q;
endmodule

// File: rtl/bag_order_mux.sv
module bag_order_mux #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0]          base_addr,
  input  logic [bag_pkg::LANE_W-1:0] beat,
  input  logic                       order_xor,
  output logic [ADDR_W-1:0]          cur_addr
);
  import bag_pkg::*;

  localparam int unsigned HI_W = ADDR_W - LANE_W;

  lane_t start_lo;
  lane_t ilv_lo;
  lane_t lin_lo;
  lane_t sel_lo;

  assign start_lo = base_addr[LANE_W-1:0];
  assign lin_lo   = lane_linear(start_lo, beat);

  // Interleaved lanes are independent per bit: build them bit by bit.
  for (genvar i = 0; i < LANE_W; i++) begin : g_ilv
    lane_t one_bit;
    always_comb begin
      one_bit = '0;
      one_bit[i] = 1'b1;
    end
    assign ilv_lo[i] = |(lane_interleave(start_lo & one_bit, beat & one_bit));
  end

  assign sel_lo   = order_xor ? ilv_lo : lin_lo;
  assign cur_addr = {base_addr[ADDR_W-1 -: HI_W], sel_lo};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              ctl_strobe_n,
  input  logic              cpu_strobe_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat
);
  import bag_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              load_fire;
  logic              step_fire;
  logic [ADDR_W-1:0] base_addr;
  lane_t             beat_w;

  bag_strobe_qual u_qual (
    .clk_en       (clk_en),
    .ctl_strobe_n (ctl_strobe_n),
    .cpu_strobe_n (cpu_strobe_n),
    .chip_en_n    (chip_en_n),
    .load_fire    (load_fire)
  );

  bag_beat_ctr u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .load_fire (load_fire),
    .adv_n     (adv_n),
    .step_fire (step_fire),
    .beat      (beat_w)
  );

  bag_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk        (clk),
    .rst        (rst),
    .load_fire  (load_fire),
    .start_addr (start_addr),
    .base_addr  (base_addr)
  );

  bag_order_mux #(.ADDR_W(ADDR_W)) u_mux (
    .base_addr (base_addr),
    .beat      (beat_w),
    .order_xor (order_xor),
    .cur_addr  (cur_addr)
  );

  assign beat = beat_w;
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              ctl_strobe_n,
  input logic              cpu_strobe_n,
  input logic              chip_en_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        beat,
  input logic              load_fire,
  input logic              step_fire
);
  logic no_load;
  assign no_load = ctl_strobe_n && (cpu_strobe_n || chip_en_n);

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !ctl_strobe_n) |=> (cur_addr == $past(start_addr) && beat == 2'd0)); // R1

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_en && ctl_strobe_n && !cpu_strobe_n && chip_en_n && adv_n)
      |=> ($stable(cur_addr) && $stable(beat))); // R2

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (clk_en && no_load && !adv_n) |=> (beat == 2'($past(beat) + 2'd1))); // R3

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clk_en && no_load && adv_n) |=> ($stable(beat) && $stable(cur_addr))); // R4

  AST_HIGH_BITS_FIXED: assert property (@(posedge clk) disable iff (rst)
    no_load |=> $stable(cur_addr[ADDR_W-1:2])); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    !(load_fire && step_fire)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat == 2'd0)); // R9

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(cur_addr) && $stable(beat))); // R10
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_bag_checker (
  .clk          (clk),
  .rst          (rst),
  .clk_en       (clk_en),
  .ctl_strobe_n (ctl_strobe_n),
  .cpu_strobe_n (cpu_strobe_n),
  .chip_en_n    (chip_en_n),
  .adv_n        (adv_n),
  .start_addr   (start_addr),
  .cur_addr     (cur_addr),
  .beat         (beat),
  .load_fire    (load_fire),
  .step_fire    (step_fire)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst, clk_en, ctl_n, cpu_n, ce_n, adv_n, order_xor;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .clk_en(clk_en), .ctl_strobe_n(ctl_n),
    .cpu_strobe_n(cpu_n), .chip_en_n(ce_n), .adv_n(adv_n),
    .order_xor(order_xor), .start_addr(start_addr),
    .cur_addr(cur_addr), .beat(beat)
  );

  // Reference ordering, written from the requirements' tables.
  function automatic logic [1:0] ref_low(input bit ilv, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k);
    if (ilv) return {s[1] ^ kk[1], s[0] ^ kk[0]};
    return 2'((int'(s) + k) % 4);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [AW-1:0] act_a, input logic [AW-1:0] exp_a,
                       input logic [1:0] act_b, input logic [1:0] exp_b);
    n_checks++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic idle_inputs();
    clk_en = 1; ctl_n = 1; cpu_n = 1; ce_n = 1; adv_n = 1;
  endtask

  task automatic t_reset();
    rst = 1; idle_inputs(); clk_en = 0; order_xor = 1; start_addr = 15'h7fff;
    tick(); tick();
    check("R9 reset clears", cur_addr, '0, beat, 2'd0);
    rst = 0; clk_en = 1;
  endtask

  // Full burst from one start, loaded via either strobe, ending with wrap.
  task automatic t_burst(input bit ilv, input logic [1:0] lo, input bit via_cpu);
    logic [AW-1:0] s;
    s = {13'h0a5b + 13'(lo), lo};
    order_xor = ilv; start_addr = s;
    if (via_cpu) begin cpu_n = 0; ce_n = 0; end else begin ctl_n = 0; ce_n = 1; end
    tick();
    idle_inputs(); start_addr = ~s;
    check(via_cpu ? "R2 cpu load" : "R1 ctl load", cur_addr, s, beat, 2'd0);
    for (int k = 1; k < 4; k++) begin
      adv_n = 0;
      tick();
      check(ilv ? "R5/R7 interleaved beat" : "R6/R7 linear beat",
            cur_addr, {s[AW-1:2], ref_low(ilv, lo, k)}, beat, 2'(k));
    end
    tick();
    adv_n = 1;
    check("R6 wrap to start", cur_addr, s, beat, 2'd0);
  endtask

  task automatic t_suspend();
    logic [AW-1:0] s;
    s = 15'h1235; order_xor = 0; start_addr = s; ctl_n = 0;
    tick(); idle_inputs();
    adv_n = 0; tick(); adv_n = 1;
    tick(); tick();
    check("R4 suspend holds", cur_addr, {s[AW-1:2], 2'd2}, beat, 2'd1);
    adv_n = 0; tick(); adv_n = 1;
    check("R3 resume after suspend", cur_addr, {s[AW-1:2], 2'd3}, beat, 2'd2);
  endtask

  task automatic t_cpu_gated();
    logic [AW-1:0] s;
    s = 15'h4442; order_xor = 1; start_addr = s; ctl_n = 0; ce_n = 0;
    tick(); idle_inputs();
    start_addr = 15'h3331; cpu_n = 0; ce_n = 1;
    tick();
    check("R2 cpu strobe ignored without chip enable", cur_addr, s, beat, 2'd0);
    adv_n = 0;
    tick();
    check("R2 ignored strobe lets advance act", cur_addr, {s[AW-1:2], 2'd3}, beat, 2'd1);
    idle_inputs();
    start_addr = 15'h2227; ctl_n = 0; ce_n = 1;
    tick(); idle_inputs();
    check("R1 ctl strobe loads with chip enable high", cur_addr, 15'h2227, beat, 2'd0);
  endtask

  task automatic t_priority();
    logic [AW-1:0] s;
    s = 15'h0101; order_xor = 0; start_addr = s; ctl_n = 0;
    tick(); idle_inputs();
    adv_n = 0; tick(); tick();
    start_addr = 15'h5556; cpu_n = 0; ce_n = 0; adv_n = 0;
    tick(); idle_inputs();
    check("R8 load beats advance", cur_addr, 15'h5556, beat, 2'd0);
  endtask

  task automatic t_freeze();
    logic [AW-1:0] s;
    s = 15'h6d29; order_xor = 1; start_addr = s; ctl_n = 0;
    tick(); idle_inputs();
    clk_en = 0; adv_n = 0; tick();
    ctl_n = 0; start_addr = 15'h0002; tick();
    check("R10 clock enable low freezes", cur_addr, s, beat, 2'd0);
    idle_inputs();
    rst = 1; clk_en = 0; tick(); rst = 0; clk_en = 1;
    check("R9 reset acts with clock enable low", cur_addr, '0, beat, 2'd0);
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++)
        t_burst(m[0], 2'(o), (o % 2) == 1);
    t_suspend();
    t_cpu_gated();
    t_priority();
    t_freeze();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule